// File: doc/BRIEF.md
# Event Counter Group with Register Port

This block holds a small bank of event counters. A 32-bit register port gives software read and write access to them. Each clock, the block sees a vector of event strobes and one stream identifier that goes with them. Every counter picks one event number and one stream filter. It advances by one on a clock edge when the group is running, the counter is switched on, its chosen event is present and the stream identifier passes its filter. Event number zero is the clock itself, so it counts every edge.

Software can preload any counter, for example to half of full scale, so that it reaches overflow after a known number of events. Three per-counter bit vectors are handled through separate write-one-to-set and write-one-to-clear addresses: counter enable, interrupt enable and overflow status. A counter that wraps past its top value raises its overflow bit. The interrupt line is high while an overflowed counter has its interrupt enabled and the global interrupt switch is on. A read-only word reports the counter count and width, and another lists the implemented events. With the default width of 40 bits, each counter takes two 32-bit words: low word first, then high word.

Top module: `pmon_group`

## Requirements
- R1: After reset, every counter, event-type and match register, the counter-enable, interrupt-enable and overflow vectors, the run bit (0xE04) and the interrupt switch (0xE50) read 0, and `irq` is low.
- R2: The word at 0xE00 reads NUM_CTR-1 in bits 5:0 and CTR_W-1 in bits 13:8, with all other bits 0 (0x00002707 by default). The word at 0xE20 has bit k set for each implemented event k < NUM_EVT (0xFF by default), and 0xE28 reads 0.
- R3: Counter n is at byte offset n*8 (bits 31:0) and n*8+4 (bits CTR_W-1:32) when CTR_W > 32, and at n*4 otherwise. A write replaces only the bits of the addressed word. A write to a counter wins over an increment on the same edge.
- R4: A counter increments by exactly one on an edge where the run bit, its enable bit and its selected event are all set and its stream filter matches. Event 0 is present on every edge, event k in 1..NUM_EVT-1 is `ev_in[k]`, and an event number of NUM_EVT or more never counts.
- R5: The event-type word for counter n is at 0x400+4n, with the event number in bits 15:0 and the span flag in bit 29. The match value is at 0xA00+4n. With span 0 the stream identifier must equal the match value. With span 1, the bits from bit 0 up to and including the lowest 0 bit of the match value are ignored, and an all-ones match value accepts every identifier.
- R6: Writing ones to 0xC00 or 0xC40 sets those bits of the counter-enable or interrupt-enable vector. Writing ones to 0xC20 or 0xC60 clears them. Zero bits have no effect. Both addresses of a pair read the current vector.
- R7: A counter that increments from all ones to zero sets its overflow bit. Ones written to 0xC80 clear overflow bits, and ones written to 0xCC0 set them. Both addresses read the vector. A wrap on the same edge as a clear leaves the bit set.
- R8: `irq` is high exactly when bit 0 of 0xE50 is set and some counter has both its overflow bit and its interrupt-enable bit set.
- R9: Reads of unmapped addresses return 0. Writes to 0xE00 and 0xE20 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_in | input | NUM_EVT | Event strobes for the current cycle |
| ev_sid | input | SID_W | Stream identifier that goes with `ev_in` |
| irq | output | 1 | Overflow interrupt, level |

## Verification
The assertions assume that addresses are word aligned and that NUM_CTR and NUM_EVT are at most 32, so that one word holds each vector. They also assume that software never writes a counter that is wrapping on the same edge. The stimulus uses only aligned addresses and the default sizes. Wraps in the random phase happen only while no counter write is in flight, because every write is issued with the event inputs idle.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

  localparam logic [11:0] A_EVTYPE  = 12'h400;
  localparam logic [11:0] A_MATCH   = 12'hA00;
  localparam logic [11:0] A_CEN_SET = 12'hC00;
  localparam logic [11:0] A_CEN_CLR = 12'hC20;
  localparam logic [11:0] A_IEN_SET = 12'hC40;
  localparam logic [11:0] A_IEN_CLR = 12'hC60;
  localparam logic [11:0] A_OVF_CLR = 12'hC80;
  localparam logic [11:0] A_OVF_SET = 12'hCC0;
  localparam logic [11:0] A_CFG     = 12'hE00;
  localparam logic [11:0] A_RUN     = 12'hE04;
  localparam logic [11:0] A_EVMAP   = 12'hE20;
  localparam logic [11:0] A_IRQ_ON  = 12'hE50;

  localparam int SPAN_POS = 29;

  // Span mode: ignore bit 0 up to and including the lowest zero of the pattern.
  function automatic logic sid_hit(logic [31:0] sid, logic [31:0] pat, logic span);
    logic [31:0] dont_care;
    dont_care = span ? (pat ^ (pat + 32'd1)) : 32'd0;
    return ((sid ^ pat) & ~dont_care) == 32'd0;
  endfunction

  function automatic logic [31:0] word_pick(logic [63:0] v, logic hi);
    return hi ? v[63:32] : v[31:0];
  endfunction

  function automatic logic [63:0] merge_word(logic [63:0] cur, logic [31:0] d,
                                             logic lo, logic hi);
    logic [63:0] r;
    r = cur;
    if (lo) r[31:0]  = d;
    if (hi) r[63:32] = d;
    return r;
  endfunction

  function automatic logic [63:0] w1_apply(logic [63:0] cur, logic [63:0] bits,
                                           logic set, logic clr);
    logic [63:0] r;
    r = cur;
    if (set) r = r | bits;
    if (clr) r = r & ~bits;
    return r;
  endfunction

endpackage

// File: rtl/pmon_ctr.sv
module pmon_ctr
  import pmon_pkg::*;
#(
  parameter int CTR_W   = 40,
  parameter int NUM_EVT = 8,
  parameter int SID_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [NUM_EVT-1:0] ev_in,
  input  logic [SID_W-1:0]   ev_sid,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic               wr_typ,
  input  logic               wr_pat,
  input  logic [31:0]        wdata,
  output logic [CTR_W-1:0]   cnt,
  output logic [15:0]        evn,
  output logic               span,
  output logic [SID_W-1:0]   pat,
  output logic               wrap
);

  localparam int EI_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic             ev_sel;
  logic             hit;
  logic             inc;
  logic             load;
  logic [CTR_W-1:0] nxt;

  always_comb begin
    if (evn == 16'd0)                 ev_sel = 1'b1;
    else if (evn < 16'(NUM_EVT))      ev_sel = ev_in[evn[EI_W-1:0]];
    else                              ev_sel = 1'b0;
  end

  assign hit  = sid_hit(32'(ev_sid), 32'(pat), span);
  assign inc  = run & ev_sel & hit;
  assign load = wr_lo | wr_hi;
  assign wrap = inc & (&cnt) & ~load;

  always_comb begin
    if (load) nxt = CTR_W'(merge_word(64'(cnt), wdata, wr_lo, wr_hi));
    else      nxt = cnt + CTR_W'(inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      evn  <= '0;
      span <= 1'b0;
      pat  <= '0;
    end else begin
      cnt <= nxt;
      if (wr_typ) begin
        evn  <= wdata[15:0];
        span <= wdata[SPAN_POS];
      end
      if (wr_pat) pat <= wdata[SID_W-1:0];
    end
  end

  // R4: without a write the count moves by at most one per edge
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

  // R4: a stopped counter keeps its value
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));

  // R7: a wrap leaves the counter at zero
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

endmodule

// File: rtl/pmon_irq.sv
module pmon_irq
  import pmon_pkg::*;
#(
  parameter int NUM_CTR = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cen_set,
  input  logic               cen_clr,
  input  logic               ien_set,
  input  logic               ien_clr,
  input  logic               ovf_set,
  input  logic               ovf_clr,
  input  logic [NUM_CTR-1:0] bits,
  input  logic [NUM_CTR-1:0] wrap,
  input  logic               irq_on,
  output logic [NUM_CTR-1:0] cen,
  output logic [NUM_CTR-1:0] ien,
  output logic [NUM_CTR-1:0] ovf,
  output logic               irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen <= '0;
      ien <= '0;
      ovf <= '0;
    end else begin
      cen <= NUM_CTR'(w1_apply(64'(cen), 64'(bits), cen_set, cen_clr));
      ien <= NUM_CTR'(w1_apply(64'(ien), 64'(bits), ien_set, ien_clr));
      ovf <= NUM_CTR'(w1_apply(64'(ovf), 64'(bits), ovf_set, ovf_clr)) | wrap;
    end
  end

  assign irq = irq_on & (|(ovf & ien));

  // R7: every wrap is recorded, even against a clear
  p_wrap_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap != '0) |=> ((ovf & $past(wrap)) == $past(wrap)));

  // R7: a clear without a wrap drops the bits
  p_clr_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && wrap == '0) |=> ((ovf & $past(bits)) == '0));

  // R8: no interrupt while the global switch is off
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_on);

endmodule

// File: rtl/pmon_group.sv
module pmon_group
  import pmon_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 40,
  parameter int NUM_EVT = 8,
  parameter int SID_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [11:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] ev_in,
  input  logic [SID_W-1:0]   ev_sid,
  output logic               irq
);

  localparam bit WIDE   = (CTR_W > 32);
  localparam int STRIDE = WIDE ? 8 : 4;
  localparam logic [31:0] CFG_WORD = {8'd0, 4'd0, 6'd0, 6'(CTR_W - 1), 2'd0, 6'(NUM_CTR - 1)};
  localparam logic [31:0] EVMAP    = 32'((64'd1 << NUM_EVT) - 64'd1);

  logic [CTR_W-1:0]   cnt_q  [NUM_CTR];
  logic [15:0]        evn_q  [NUM_CTR];
  logic               span_q [NUM_CTR];
  logic [SID_W-1:0]   pat_q  [NUM_CTR];
  logic [NUM_CTR-1:0] wrap_v;
  logic [NUM_CTR-1:0] cen, ien, ovf;
  logic               run_q, irq_on_q;

  // Global run and interrupt switches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      irq_on_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == A_RUN)    run_q    <= reg_wdata[0];
      if (reg_addr == A_IRQ_ON) irq_on_q <= reg_wdata[0];
    end
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    localparam logic [11:0] CA = 12'(g * STRIDE);
    logic wr_lo, wr_hi, wr_typ, wr_pat;
    assign wr_lo  = reg_wr && (reg_addr == CA);
    assign wr_hi  = WIDE && reg_wr && (reg_addr == CA + 12'd4);
    assign wr_typ = reg_wr && (reg_addr == A_EVTYPE + 12'(4 * g));
    assign wr_pat = reg_wr && (reg_addr == A_MATCH + 12'(4 * g));

    pmon_ctr #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT), .SID_W(SID_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q & cen[g]),
      .ev_in  (ev_in),
      .ev_sid (ev_sid),
      .wr_lo  (wr_lo),
      .wr_hi  (wr_hi),
      .wr_typ (wr_typ),
      .wr_pat (wr_pat),
      .wdata  (reg_wdata),
      .cnt    (cnt_q[g]),
      .evn    (evn_q[g]),
      .span   (span_q[g]),
      .pat    (pat_q[g]),
      .wrap   (wrap_v[g])
    );
  end

  pmon_irq #(.NUM_CTR(NUM_CTR)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cen_set (reg_wr && reg_addr == A_CEN_SET),
    .cen_clr (reg_wr && reg_addr == A_CEN_CLR),
    .ien_set (reg_wr && reg_addr == A_IEN_SET),
    .ien_clr (reg_wr && reg_addr == A_IEN_CLR),
    .ovf_set (reg_wr && reg_addr == A_OVF_SET),
    .ovf_clr (reg_wr && reg_addr == A_OVF_CLR),
    .bits    (reg_wdata[NUM_CTR-1:0]),
    .wrap    (wrap_v),
    .irq_on  (irq_on_q),
    .cen     (cen),
    .ien     (ien),
    .ovf     (ovf),
    .irq     (irq)
  );

  // Read multiplexer; unmapped addresses give zero
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (reg_addr == 12'(i * STRIDE))
        reg_rdata = word_pick(64'(cnt_q[i]), 1'b0);
      if (WIDE && reg_addr == 12'(i * STRIDE + 4))
        reg_rdata = word_pick(64'(cnt_q[i]), 1'b1);
      if (reg_addr == A_EVTYPE + 12'(4 * i))
        reg_rdata = {2'b00, span_q[i], 13'd0, evn_q[i]};
      if (reg_addr == A_MATCH + 12'(4 * i))
        reg_rdata = 32'(pat_q[i]);
    end
    case (reg_addr)
      A_CEN_SET, A_CEN_CLR: reg_rdata = 32'(cen);
      A_IEN_SET, A_IEN_CLR: reg_rdata = 32'(ien);
      A_OVF_SET, A_OVF_CLR: reg_rdata = 32'(ovf);
      A_CFG:                reg_rdata = CFG_WORD;
      A_RUN:                reg_rdata = {31'd0, run_q};
      A_EVMAP:              reg_rdata = EVMAP;
      A_IRQ_ON:             reg_rdata = {31'd0, irq_on_q};
      default: ;
    endcase
  end

  // R9: the configuration word never changes
  p_cfg_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CFG) |-> (reg_rdata == CFG_WORD));

endmodule

// File: tb/pmon_group_test.sv
`timescale 1ns/1ps
module pmon_group_test;

  localparam int NC = 8;
  localparam int CW = 40;
  localparam int NE = 8;
  localparam int SW = 16;
  localparam logic [63:0] CMAX = (64'd1 << CW) - 64'd1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NE-1:0] ev_in = '0;
  logic [SW-1:0] ev_sid = '0;
  logic          irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pmon_group #(.NUM_CTR(NC), .CTR_W(CW), .NUM_EVT(NE), .SID_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in(ev_in),
    .ev_sid(ev_sid), .irq(irq)
  );

  // Reference state
  logic [63:0] m_cnt  [NC];
  logic [15:0] m_evn  [NC];
  logic        m_span [NC];
  logic [15:0] m_pat  [NC];
  logic [7:0]  m_cen = '0, m_ien = '0, m_ovf = '0;
  logic        m_run = 1'b0, m_irqon = 1'b0;

  function automatic bit b_match(logic [15:0] sid, logic [15:0] pat, logic span);
    int y;
    if (!span) return sid == pat;
    y = 0;
    while (y < 16 && pat[y]) y++;
    y++;
    if (y >= 16) return 1'b1;
    return (sid >> y) == (pat >> y);
  endfunction

  function automatic void m_tick(logic [7:0] ev, logic [15:0] sid);
    bit sel;
    for (int i = 0; i < NC; i++) begin
      if (m_run && m_cen[i]) begin
        if (m_evn[i] == 0)       sel = 1'b1;
        else if (m_evn[i] < NE)  sel = ev[m_evn[i][2:0]];
        else                     sel = 1'b0;
        if (sel && b_match(sid, m_pat[i], m_span[i])) begin
          if (m_cnt[i] == CMAX) begin
            m_cnt[i] = 64'd0;
            m_ovf[i] = 1'b1;
          end else m_cnt[i] = m_cnt[i] + 64'd1;
        end
      end
    end
  endfunction

  function automatic void m_apply(logic [11:0] a, logic [31:0] d);
    int i;
    if (a < 12'(NC * 8)) begin
      i = int'(a) / 8;
      if (a[2]) m_cnt[i][39:32] = d[7:0];
      else      m_cnt[i][31:0]  = d;
    end else if (a >= 12'h400 && a < 12'h400 + 12'(4 * NC)) begin
      i = int'(a - 12'h400) / 4;
      m_evn[i]  = d[15:0];
      m_span[i] = d[29];
    end else if (a >= 12'hA00 && a < 12'hA00 + 12'(4 * NC)) begin
      i = int'(a - 12'hA00) / 4;
      m_pat[i] = d[15:0];
    end else begin
      case (a)
        12'hC00: m_cen = m_cen | d[7:0];
        12'hC20: m_cen = m_cen & ~d[7:0];
        12'hC40: m_ien = m_ien | d[7:0];
        12'hC60: m_ien = m_ien & ~d[7:0];
        12'hC80: m_ovf = m_ovf & ~d[7:0];
        12'hCC0: m_ovf = m_ovf | d[7:0];
        12'hE04: m_run = d[0];
        12'hE50: m_irqon = d[0];
        default: ;
      endcase
    end
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    int i;
    if (a < 12'(NC * 8)) begin
      i = int'(a) / 8;
      return a[2] ? m_cnt[i][63:32] : m_cnt[i][31:0];
    end
    if (a >= 12'h400 && a < 12'h400 + 12'(4 * NC)) begin
      i = int'(a - 12'h400) / 4;
      return {2'b00, m_span[i], 13'd0, m_evn[i]};
    end
    if (a >= 12'hA00 && a < 12'hA00 + 12'(4 * NC)) begin
      i = int'(a - 12'hA00) / 4;
      return 32'(m_pat[i]);
    end
    case (a)
      12'hC00, 12'hC20: return 32'(m_cen);
      12'hC40, 12'hC60: return 32'(m_ien);
      12'hC80, 12'hCC0: return 32'(m_ovf);
      12'hE00: return 32'h0000_2707;
      12'hE04: return 32'(m_run);
      12'hE20: return 32'h0000_00FF;
      12'hE50: return 32'(m_irqon);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic m_irq();
    return m_irqon & (|(m_ovf & m_ien));
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Every task starts and ends at a falling edge; each consumed edge is modelled.
  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    m_tick(ev_in, ev_sid);
    m_apply(a, d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ck_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    reg_addr = a;
    #1 d = reg_rdata;
    check(tag, 64'(d), 64'(exp));
    m_tick(ev_in, ev_sid);
    @(negedge clk);
  endtask

  task automatic ck_model(input string tag, input logic [11:0] a);
    ck_rd(tag, a, m_read(a));
  endtask

  task automatic hold(input logic [7:0] ev, input logic [15:0] sid, input int k);
    for (int j = 0; j < k; j++) begin
      ev_in = ev; ev_sid = sid;
      m_tick(ev, sid);
      @(negedge clk);
    end
    ev_in = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    for (int i = 0; i < NC; i++) begin
      m_cnt[i] = '0; m_evn[i] = '0; m_span[i] = 1'b0; m_pat[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < NC; i++) begin
      ck_rd("R1 counter lo", 12'(8 * i), 32'd0);
      ck_rd("R1 counter hi", 12'(8 * i + 4), 32'd0);
      ck_rd("R1 evtype", 12'h400 + 12'(4 * i), 32'd0);
    end
    ck_rd("R1 cen", 12'hC00, 32'd0);
    ck_rd("R1 ien", 12'hC40, 32'd0);
    ck_rd("R1 ovf", 12'hC80, 32'd0);
    ck_rd("R1 run", 12'hE04, 32'd0);
    ck_rd("R1 irq switch", 12'hE50, 32'd0);
    check("R1 irq", 64'(irq), 64'd0);

    // R2: configuration and event map
    ck_rd("R2 cfg", 12'hE00, 32'h0000_2707);
    ck_rd("R2 evmap", 12'hE20, 32'h0000_00FF);
    ck_rd("R2 evmap upper", 12'hE28, 32'd0);

    // R9: read-only words and unmapped space
    reg_write(12'hE00, 32'hFFFF_FFFF);
    ck_rd("R9 cfg after write", 12'hE00, 32'h0000_2707);
    reg_write(12'hE20, 32'h0);
    ck_rd("R9 evmap after write", 12'hE20, 32'h0000_00FF);
    ck_rd("R9 unmapped 0x800", 12'h800, 32'd0);
    ck_rd("R9 unmapped 0xE24", 12'hE24, 32'd0);
    ck_rd("R9 unmapped 0xFFC", 12'hFFC, 32'd0);

    // R6: set/clear pairs
    reg_write(12'hC00, 32'hA5);
    ck_rd("R6 cen set view", 12'hC00, 32'hA5);
    ck_rd("R6 cen clear view", 12'hC20, 32'hA5);
    reg_write(12'hC20, 32'h05);
    ck_rd("R6 cen after clear", 12'hC00, 32'hA0);
    reg_write(12'hC00, 32'h0);
    ck_rd("R6 cen zero write", 12'hC00, 32'hA0);
    reg_write(12'hC40, 32'h3C);
    reg_write(12'hC60, 32'h0C);
    ck_rd("R6 ien", 12'hC60, 32'h30);
    reg_write(12'hC20, 32'hFF);
    reg_write(12'hC60, 32'hFF);

    // R3: word layout of a wide counter
    reg_write(12'h010, 32'hDEAD_BEEF);
    reg_write(12'h014, 32'hFFFF_FF12);
    ck_rd("R3 lo word", 12'h010, 32'hDEAD_BEEF);
    ck_rd("R3 hi word", 12'h014, 32'h0000_0012);

    // R4: event 0 counts every edge
    reg_write(12'h400, 32'h0);
    reg_write(12'h000, 32'h0);
    reg_write(12'h004, 32'h0);
    reg_write(12'hC00, 32'h01);
    reg_write(12'hE04, 32'h1);
    hold(8'h00, 16'h0, 10);
    reg_write(12'hE04, 32'h0);
    ck_rd("R4 cycle count", 12'h000, 32'd11);

    // R3: write wins over an increment on the same edge
    reg_write(12'hE04, 32'h1);
    reg_write(12'h000, 32'd100);
    ck_rd("R3 write wins", 12'h000, 32'd100);
    reg_write(12'hE04, 32'h0);
    ck_rd("R4 count resumes", 12'h000, 32'd102);
    reg_write(12'hC20, 32'h01);

    // R4: event number out of range; counter enable gating
    reg_write(12'h410, 32'h2000_0009);
    reg_write(12'hA10, 32'h0000_FFFF);
    reg_write(12'h414, 32'h2000_0003);
    reg_write(12'hA14, 32'h0000_FFFF);
    reg_write(12'hC00, 32'h30);
    reg_write(12'hE04, 32'h1);
    hold(8'hFF, 16'h3, 5);
    hold(8'h08, 16'h7, 4);
    hold(8'hF7, 16'h1, 3);
    reg_write(12'hC20, 32'h20);
    hold(8'h08, 16'h0, 2);
    reg_write(12'hE04, 32'h0);
    ck_rd("R4 out-of-range event", 12'h020, 32'd0);
    ck_rd("R4 selected event", 12'h028, 32'd9);
    reg_write(12'hC20, 32'hFF);

    // R5: exact and span filters
    reg_write(12'h404, 32'h2000_0001);
    reg_write(12'hA04, 32'h42);
    reg_write(12'h40C, 32'h0000_0001);
    reg_write(12'hA0C, 32'h42);
    reg_write(12'hC00, 32'h0A);
    reg_write(12'hE04, 32'h1);
    hold(8'h02, 16'h42, 3);
    hold(8'h02, 16'h43, 2);
    hold(8'h02, 16'h44, 4);
    hold(8'h02, 16'hC2, 1);
    reg_write(12'hE04, 32'h0);
    ck_rd("R5 span filter", 12'h008, 32'd5);
    ck_rd("R5 exact filter", 12'h018, 32'd3);
    ck_rd("R5 evtype readback", 12'h404, 32'h2000_0001);
    ck_rd("R5 match readback", 12'hA04, 32'h42);
    reg_write(12'hC20, 32'hFF);

    // R7 / R8: wrap, overflow views, interrupt
    reg_write(12'h408, 32'h2000_0001);
    reg_write(12'hA08, 32'h0000_FFFF);
    reg_write(12'h010, 32'hFFFF_FFFE);
    reg_write(12'h014, 32'h0000_00FF);
    reg_write(12'hC00, 32'h04);
    reg_write(12'hE04, 32'h1);
    hold(8'h02, 16'h9, 1);
    ck_rd("R7 no overflow yet", 12'hC80, 32'd0);
    hold(8'h02, 16'h9, 1);
    ck_rd("R7 wrapped count", 12'h010, 32'd0);
    ck_rd("R7 overflow clear view", 12'hC80, 32'h04);
    ck_rd("R7 overflow set view", 12'hCC0, 32'h04);
    check("R8 irq off without enables", 64'(irq), 64'd0);
    reg_write(12'hC40, 32'h04);
    check("R8 irq off without switch", 64'(irq), 64'd0);
    reg_write(12'hE50, 32'h1);
    check("R8 irq raised", 64'(irq), 64'd1);
    reg_write(12'hC80, 32'h04);
    check("R8 irq after clear", 64'(irq), 64'd0);
    ck_rd("R7 cleared", 12'hC80, 32'd0);
    reg_write(12'hCC0, 32'h04);
    check("R8 irq after set", 64'(irq), 64'd1);
    reg_write(12'h010, 32'hFFFF_FFFF);
    reg_write(12'h014, 32'h0000_00FF);
    ev_in = 8'h02; ev_sid = 16'h0;
    reg_write(12'hC80, 32'h04);
    ev_in = '0;
    m_ovf[2] = 1'b1;
    ck_rd("R7 wrap beats clear", 12'hC80, 32'h04);
    ck_rd("R7 wrap beats clear count", 12'h010, 32'd0);
    check("R8 irq kept", 64'(irq), 64'd1);
    reg_write(12'hE50, 32'h0);
    check("R8 irq switch off", 64'(irq), 64'd0);
    reg_write(12'hE04, 32'h0);

    // Random phase: R4 R5 R6 R7 R8 against the reference
    for (int r = 0; r < 4; r++) begin
      reg_write(12'hE04, 32'h0);
      for (int i = 0; i < NC; i++) begin
        reg_write(12'h400 + 12'(4 * i),
                  {2'b00, 1'($urandom % 2), 13'd0, 16'(1 + $urandom % 8)});
        reg_write(12'hA00 + 12'(4 * i),
                  ($urandom % 4 == 0) ? 32'h0000_FFFF : 32'($urandom % 16));
        if ($urandom % 2 == 1) begin
          reg_write(12'(8 * i), 32'hFFFF_FF00 | 32'($urandom % 256));
          reg_write(12'(8 * i + 4), 32'hFF);
        end else begin
          reg_write(12'(8 * i), 32'($urandom % 1000));
          reg_write(12'(8 * i + 4), 32'h0);
        end
      end
      reg_write(12'hC00, 32'($urandom));
      reg_write(12'hC20, 32'($urandom));
      reg_write(12'hC40, 32'($urandom));
      reg_write(12'hC60, 32'($urandom));
      reg_write(12'hC80, 32'($urandom));
      reg_write(12'hE50, 32'($urandom % 2));
      reg_write(12'hE04, 32'h1);
      for (int t = 0; t < 300; t++)
        hold(8'($urandom), 16'($urandom % 16), 1);
      reg_write(12'hE04, 32'h0);
      for (int i = 0; i < NC; i++) begin
        ck_model("R4 random count lo", 12'(8 * i));
        ck_model("R4 random count hi", 12'(8 * i + 4));
      end
      ck_model("R7 random overflow", 12'hC80);
      ck_model("R6 random cen", 12'hC20);
      ck_model("R6 random ien", 12'hC40);
      check("R8 random irq", 64'(irq), 64'(m_irq()));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule